// File: doc/BRIEF.md
# Suspend-State Remote Wake Controller

This block watches the wake sources of a USB-attached network device while it is suspended and decides when the device must leave suspend. There are eleven general-purpose pins, a PHY link-up level and a single-cycle good-frame strobe from the MAC receive filter. A host first selects a suspend mode and then strobes entry. The block holds the current power state. On the first permitted wake condition it returns to NORMAL and issues a one-cycle remote_wake pulse, with an exit request pulse alongside it.

Pin levels cross into the clock domain through a synchronizer. A pin counts as a wake condition only when its synchronized level matches its polarity bit for two consecutive clocks. Whether a pin is armed depends on how it is set up. Each of the lower pins carries an explicit arm bit. Each of the upper pins is armed only while it is configured as a plain input. One lower pin can be switched over to follow the PHY link-up level. A status bit per pin and one for the good-frame path record each source that fires. These bits stay set until software clears them with a write-one strobe.

Top module: `swake_ctrl`

## Requirements
- R1: After reset the state is NORMAL (code 0). remote_wake_o, exit_req_o, every pin status bit and the frame status bit are 0.
- R2: The state is encoded 0 = NORMAL and 1, 2, 3, 4 = SUSPEND0, SUSPEND1, SUSPEND2, SUSPEND3. A one-cycle susp_enter_i taken while in NORMAL loads susp_mode_i into the state on the next clock, but only when the mode is 1 to 4. Mode 0, mode 5 to 7, and entry strobes seen while suspended leave the state unchanged.
- R3: A pin is a wake condition only when its synchronized level equals its polarity bit (1 = active high, 0 = active low) on two consecutive clocks. An active level that lasts one clock causes nothing.
- R4: Pins 0 to 7 are armed only when both pin_arm_i[k] and pin_wake_en_i[k] are 1.
- R5: Pins 8 to 10 have no arm bit. Each is armed when pin_wake_en_i is 1, its 2-bit function field in upper_func_i (pin 8 in bits 1:0, pin 9 in 3:2, pin 10 in 5:4) is 00b, and its direction bit in upper_dir_i (pin 8 in bit 0) is 0.
- R6: While linkup_en_i is 1, pin 7 takes the phy_linkup_i level as its source, active high. The external pin 7 level and the pin 7 arm, enable and polarity bits are then ignored. This source is honoured only in NORMAL, SUSPEND0 and SUSPEND3, and it sets status bit 7.
- R7: A good_frame_i strobe fires only in SUSPEND3, and only when every bit of wol_ev_en_i is 0. No global wake-on-LAN enable takes part in this path.
- R8: A permitted wake source seen in any suspend state returns the state to NORMAL on the next clock. In that same cycle remote_wake_o and exit_req_o are each high for exactly one cycle, and they pulse once per exit.
- R9: Status bits are sticky: pin k sets pin_stat_o[k], and the good-frame path sets frame_stat_o. Setting stat_clr_i[k] clears pin bit k, and stat_clr_i[11] clears the frame bit. When a set and a clear land in the same cycle, the bit stays 1. A clear on another bit leaves the bit untouched.
- R10: An armed pin or link-up condition seen while in NORMAL sets its status bit, but raises no pulse and causes no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| susp_mode_i | input | 3 | Requested suspend mode code |
| susp_enter_i | input | 1 | Strobe to enter the requested suspend mode |
| pin_i | input | 11 | Raw general-purpose pin levels |
| pin_pol_i | input | 11 | Per-pin active level |
| pin_wake_en_i | input | 11 | Per-pin wake enable |
| pin_arm_i | input | 8 | Explicit arm bits for pins 0 to 7 |
| upper_func_i | input | 6 | Function fields of pins 8 to 10, two bits each |
| upper_dir_i | input | 3 | Direction bits of pins 8 to 10 (1 = output) |
| linkup_en_i | input | 1 | Route the PHY link-up level onto pin 7 |
| phy_linkup_i | input | 1 | PHY link-up level |
| good_frame_i | input | 1 | Single-cycle good-frame strobe from the receive filter |
| wol_ev_en_i | input | 4 | Wake-on-LAN event enables; all must be 0 for a good-frame wake |
| stat_clr_i | input | 12 | Write-one-to-clear strobes: bits 10:0 pins, bit 11 frame |
| state_o | output | 3 | Current power state code |
| remote_wake_o | output | 1 | One-cycle remote wake pulse |
| exit_req_o | output | 1 | One-cycle return-to-NORMAL request |
| pin_stat_o | output | 11 | Sticky per-pin wake status |
| frame_stat_o | output | 1 | Sticky good-frame wake status |

## Verification
The bench builds the block with its default parameters: eleven pins, of which the lower eight carry arm bits, link-up routed onto pin 7, four wake-on-LAN enables and a two-stage synchronizer. With eight armed pins and three upper pins, every arming rule (explicit bit, function field, direction bit) and the pin 7 takeover can be reached from one vector table. The two-stage synchronizer keeps the path from pin to pulse at four clocks. A one-clock glitch therefore shows cleanly as a non-event, and a sustained level shows as exactly one exit.

// File: rtl/swake_pkg.sv
package swake_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_SUSP0  = 3'd1,
    ST_SUSP1  = 3'd2,
    ST_SUSP2  = 3'd3,
    ST_SUSP3  = 3'd4
  } pwr_state_e;

  // a mode code names a suspend state
  function automatic logic is_suspend(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

  // states in which the link-up source may act
  function automatic logic link_permit(input pwr_state_e st);
    return (st == ST_NORMAL) || (st == ST_SUSP0) || (st == ST_SUSP3);
  endfunction

  // states in which a good frame may act
  function automatic logic frame_permit(input pwr_state_e st);
    return st == ST_SUSP3;
  endfunction

  // synchronized level equals the selected active level
  function automatic logic level_match(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // upper pin is a plain input: function 00b, direction input
  function automatic logic upper_is_input(input logic [1:0] func, input logic dir);
    return (func == 2'b00) && !dir;
  endfunction

endpackage

// File: rtl/swake_pin_qual.sv
module swake_pin_qual
  import swake_pkg::*;
#(
  parameter int WIDTH       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] qual_o
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   match_c;
    logic                   match_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q  <= '0;
        match_q <= 1'b0;
      end else begin
        sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        match_q <= match_c;
      end
    end

    assign match_c   = level_match(sync_q[LAST], pol_i[g]);
    assign qual_o[g] = match_c & match_q;
  end

endmodule

// File: rtl/swake_status.sv
module swake_status #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] stat_o
);

  logic [WIDTH-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[b] && !clr_i[b]) |=> stat_q[b]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> stat_q[b]); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !stat_q[b]); // R9
  end

endmodule

// File: rtl/swake_fsm.sv
module swake_fsm
  import swake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       enter_i,
  input  logic       wake_req_i,
  output pwr_state_e state_o,
  output logic       remote_wake_o,
  output logic       exit_req_o
);

  pwr_state_e state_q;
  logic       pulse_q;
  logic       wake_fire;
  logic       enter_ok;

  assign wake_fire = wake_req_i && (state_q != ST_NORMAL);
  assign enter_ok  = enter_i && (state_q == ST_NORMAL) && is_suspend(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wake_fire;
      if (wake_fire)     state_q <= ST_NORMAL;
      else if (enter_ok) state_q <= pwr_state_e'(mode_i);
    end
  end

  assign state_o       = state_q;
  assign remote_wake_o = pulse_q;
  assign exit_req_o    = pulse_q;

  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= ST_SUSP3); // R2
  AST_ENTRY_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_NORMAL && state_q != $past(state_q))
      |-> ($past(enter_i) && $past(mode_i) == state_q)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake_o |=> !remote_wake_o); // R8
  AST_PULSE_LEAVES_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake_o |-> (state_q == ST_NORMAL && $past(state_q) != ST_NORMAL)); // R10

endmodule

// File: rtl/swake_ctrl.sv
module swake_ctrl
  import swake_pkg::*;
#(
  parameter int NUM_PINS    = 11,
  parameter int NUM_EXPL    = 8,
  parameter int LINK_PIN    = 7,
  parameter int NUM_WOL     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [2:0]                     susp_mode_i,
  input  logic                           susp_enter_i,
  input  logic [NUM_PINS-1:0]            pin_i,
  input  logic [NUM_PINS-1:0]            pin_pol_i,
  input  logic [NUM_PINS-1:0]            pin_wake_en_i,
  input  logic [NUM_EXPL-1:0]            pin_arm_i,
  input  logic [2*(NUM_PINS-NUM_EXPL)-1:0] upper_func_i,
  input  logic [NUM_PINS-NUM_EXPL-1:0]   upper_dir_i,
  input  logic                           linkup_en_i,
  input  logic                           phy_linkup_i,
  input  logic                           good_frame_i,
  input  logic [NUM_WOL-1:0]             wol_ev_en_i,
  input  logic [NUM_PINS:0]              stat_clr_i,
  output logic [2:0]                     state_o,
  output logic                           remote_wake_o,
  output logic                           exit_req_o,
  output logic [NUM_PINS-1:0]            pin_stat_o,
  output logic                           frame_stat_o
);

  localparam int STAT_W    = NUM_PINS + 1;
  localparam int FRAME_BIT = NUM_PINS;

  pwr_state_e          cur_state;
  logic [NUM_PINS-1:0] raw_lvl;
  logic [NUM_PINS-1:0] eff_pol;
  logic [NUM_PINS-1:0] qual;
  logic [NUM_PINS-1:0] pin_enable;
  logic [NUM_PINS-1:0] pin_permit;
  logic [NUM_PINS-1:0] pin_hit;
  logic                frame_hit;
  logic [STAT_W-1:0]   stat_set;
  logic [STAT_W-1:0]   stat_all;
  logic                wake_req;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_src
    logic base_en;
    if (k < NUM_EXPL) begin : g_expl
      assign base_en = pin_arm_i[k] & pin_wake_en_i[k];
    end else begin : g_upper
      assign base_en = upper_is_input(upper_func_i[2*(k-NUM_EXPL) +: 2],
                                      upper_dir_i[k-NUM_EXPL]) & pin_wake_en_i[k];
    end
    if (k == LINK_PIN) begin : g_link
      assign raw_lvl[k]    = linkup_en_i ? phy_linkup_i : pin_i[k];
      assign eff_pol[k]    = linkup_en_i ? 1'b1 : pin_pol_i[k];
      assign pin_enable[k] = linkup_en_i ? 1'b1 : base_en;
      assign pin_permit[k] = linkup_en_i ? link_permit(cur_state) : 1'b1;
    end else begin : g_plain
      assign raw_lvl[k]    = pin_i[k];
      assign eff_pol[k]    = pin_pol_i[k];
      assign pin_enable[k] = base_en;
      assign pin_permit[k] = 1'b1;
    end
  end

  swake_pin_qual #(
    .WIDTH       (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_lvl),
    .pol_i  (eff_pol),
    .qual_o (qual)
  );

  assign pin_hit   = qual & pin_enable & pin_permit;
  assign frame_hit = good_frame_i && (wol_ev_en_i == '0) && frame_permit(cur_state);
  assign stat_set  = {frame_hit, pin_hit};
  assign wake_req  = |stat_set;

  swake_status #(
    .WIDTH (STAT_W)
  ) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stat_set),
    .clr_i  (stat_clr_i),
    .stat_o (stat_all)
  );

  swake_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (susp_mode_i),
    .enter_i       (susp_enter_i),
    .wake_req_i    (wake_req),
    .state_o       (cur_state),
    .remote_wake_o (remote_wake_o),
    .exit_req_o    (exit_req_o)
  );

  assign state_o      = cur_state;
  assign pin_stat_o   = stat_all[NUM_PINS-1:0];
  assign frame_stat_o = stat_all[FRAME_BIT];

  AST_FRAME_ONLY_SUSP3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set[FRAME_BIT] |-> (state_o == 3'd4 && wol_ev_en_i == '0)); // R7
  AST_LINK_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    (linkup_en_i && stat_set[LINK_PIN])
      |-> (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd4)); // R6
  AST_EXIT_WITH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake_o |-> $past(wake_req)); // R8

endmodule

// File: tb/swake_ctrl_tb.sv
`timescale 1ns/1ps
module swake_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  susp_mode_i;
  logic        susp_enter_i;
  logic [10:0] pin_i, pin_pol_i, pin_wake_en_i;
  logic [7:0]  pin_arm_i;
  logic [5:0]  upper_func_i;
  logic [2:0]  upper_dir_i;
  logic        linkup_en_i, phy_linkup_i, good_frame_i;
  logic [3:0]  wol_ev_en_i;
  logic [11:0] stat_clr_i;
  logic [2:0]  state_o;
  logic        remote_wake_o, exit_req_o, frame_stat_o;
  logic [10:0] pin_stat_o;

  int checks = 0;
  int fails  = 0;
  int wake_cnt = 0;
  int exit_cnt = 0;

  always #4 clk = ~clk;

  swake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .susp_mode_i(susp_mode_i), .susp_enter_i(susp_enter_i),
    .pin_i(pin_i), .pin_pol_i(pin_pol_i), .pin_wake_en_i(pin_wake_en_i),
    .pin_arm_i(pin_arm_i), .upper_func_i(upper_func_i), .upper_dir_i(upper_dir_i),
    .linkup_en_i(linkup_en_i), .phy_linkup_i(phy_linkup_i), .good_frame_i(good_frame_i),
    .wol_ev_en_i(wol_ev_en_i), .stat_clr_i(stat_clr_i), .state_o(state_o),
    .remote_wake_o(remote_wake_o), .exit_req_o(exit_req_o),
    .pin_stat_o(pin_stat_o), .frame_stat_o(frame_stat_o)
  );

  always @(posedge clk) begin
    if (remote_wake_o) wake_cnt++;
    if (exit_req_o)    exit_cnt++;
  end

  // fields: [14] exp_stat [13] exp_wake [12:10] mode [9] dir [8:7] func
  //         [6] wake_en [5] arm [4] pol [3:0] pin
  localparam int NVEC = 12;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'd1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 4'd0},
    {1'b1, 1'b1, 3'd2, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd3},
    {1'b0, 1'b0, 3'd3, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd5},
    {1'b0, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 4'd6},
    {1'b1, 1'b1, 3'd4, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd7},
    {1'b1, 1'b1, 3'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd8},
    {1'b0, 1'b0, 3'd2, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 4'd9},
    {1'b0, 1'b0, 3'd3, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd10},
    {1'b1, 1'b1, 3'd4, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd10},
    {1'b1, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 4'd2},
    {1'b1, 1'b1, 3'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1},
    {1'b1, 1'b1, 3'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 4'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    susp_mode_i = 3'd0; susp_enter_i = 1'b0;
    pin_i = '0; pin_pol_i = '1; pin_wake_en_i = '0; pin_arm_i = '0;
    upper_func_i = '0; upper_dir_i = '0;
    linkup_en_i = 1'b0; phy_linkup_i = 1'b0; good_frame_i = 1'b0;
    wol_ev_en_i = '0; stat_clr_i = '0;
  endtask

  // reset with whatever configuration is already applied
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic enter(input logic [2:0] mode);
    @(negedge clk); susp_mode_i = mode; susp_enter_i = 1'b1;
    @(negedge clk); susp_enter_i = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk); good_frame_i = 1'b1;
    @(negedge clk); good_frame_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear(input logic [11:0] mask);
    @(negedge clk); stat_clr_i = mask;
    @(negedge clk); stat_clr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    int w0;
    int x0;
    rst_n = 1'b0;
    idle_inputs();
    do_reset();

    // R1: reset state
    chk("R1 state", state_o, 3'd0);
    chk("R1 pulse", {remote_wake_o, exit_req_o}, 2'b00);
    chk("R1 status", {frame_stat_o, pin_stat_o}, 12'h000);

    // R2: illegal mode and strobes while suspended are ignored
    enter(3'd5);
    chk("R2 mode5 ignored", state_o, 3'd0);
    enter(3'd3);
    chk("R2 enter SUSPEND2", state_o, 3'd3);
    enter(3'd1);
    chk("R2 enter while suspended ignored", state_o, 3'd3);

    // vector table: R3 R4 R5 R8 R10 across pin arming rules
    for (int i = 0; i < NVEC; i++) begin
      logic [14:0] v;
      logic [3:0]  pn;
      v  = VEC[i];
      pn = v[3:0];
      idle_inputs();
      pin_pol_i     = {11{v[4]}};
      pin_i         = v[4] ? 11'h000 : 11'h7FF;
      pin_arm_i     = v[5] ? 8'hFF : 8'h00;
      pin_wake_en_i = v[6] ? (11'd1 << pn) : 11'd0;
      upper_func_i  = {3{v[8:7]}};
      upper_dir_i   = {3{v[9]}};
      do_reset();
      enter(v[12:10]);
      chk($sformatf("R2 vec%0d entry", i), state_o, v[12:10]);
      w0 = wake_cnt; x0 = exit_cnt;
      @(negedge clk); pin_i[pn] = v[4];
      repeat (8) @(negedge clk);
      chk($sformatf("R4 R5 vec%0d wake count", i), wake_cnt - w0, v[13] ? 1 : 0);
      chk($sformatf("R8 vec%0d exit count", i), exit_cnt - x0, v[13] ? 1 : 0);
      chk($sformatf("R8 vec%0d state", i), state_o, v[13] ? 3'd0 : v[12:10]);
      chk($sformatf("R9 R10 vec%0d status", i), pin_stat_o, v[14] ? (11'd1 << pn) : 11'd0);
    end

    // R3: one-clock glitch ignored, held level wakes
    idle_inputs();
    pin_arm_i = 8'h01; pin_wake_en_i = 11'h001;
    do_reset();
    enter(3'd1);
    w0 = wake_cnt; x0 = exit_cnt;
    @(negedge clk); pin_i[0] = 1'b1;
    @(negedge clk); pin_i[0] = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 glitch no wake", wake_cnt - w0, 0);
    chk("R3 glitch state kept", state_o, 3'd1);
    chk("R3 glitch no status", pin_stat_o, 11'h000);
    @(negedge clk); pin_i[0] = 1'b1;
    repeat (12) @(negedge clk);
    // R8 and R10: one pulse although the level stays active in NORMAL
    chk("R8 single pulse", wake_cnt - w0, 1);
    chk("R8 single exit", exit_cnt - x0, 1);
    chk("R10 normal no state change", state_o, 3'd0);

    // R9: set beats clear while the level is still active
    clear(12'h001);
    @(negedge clk);
    chk("R9 set wins over clear", pin_stat_o[0], 1'b1);
    clear(12'h800);
    chk("R9 other bit clear no effect", pin_stat_o[0], 1'b1);
    @(negedge clk); pin_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    clear(12'h001);
    chk("R9 write one clears", pin_stat_o[0], 1'b0);

    // R6: link-up in SUSPEND1 is not honoured
    idle_inputs();
    linkup_en_i = 1'b1;
    do_reset();
    enter(3'd2);
    w0 = wake_cnt;
    @(negedge clk); phy_linkup_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 link in SUSPEND1 no wake", wake_cnt - w0, 0);
    chk("R6 link in SUSPEND1 no status", pin_stat_o[7], 1'b0);

    // R6: pin 7 level ignored under link-up, link-up wakes in SUSPEND0
    idle_inputs();
    linkup_en_i = 1'b1; pin_arm_i = 8'h80; pin_wake_en_i = 11'h080;
    do_reset();
    enter(3'd1);
    w0 = wake_cnt;
    @(negedge clk); pin_i[7] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 pin 7 level ignored", wake_cnt - w0, 0);
    @(negedge clk); phy_linkup_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 link wake SUSPEND0", wake_cnt - w0, 1);
    chk("R6 link status bit 7", pin_stat_o, 11'h080);

    // R6: link-up wakes in SUSPEND3 without pin 7 enables
    idle_inputs();
    linkup_en_i = 1'b1;
    do_reset();
    enter(3'd4);
    w0 = wake_cnt;
    @(negedge clk); phy_linkup_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 link wake SUSPEND3", wake_cnt - w0, 1);

    // R7: good frame only in SUSPEND3 with all event enables clear
    idle_inputs();
    do_reset();
    enter(3'd3);
    w0 = wake_cnt;
    frame_pulse();
    chk("R7 frame in SUSPEND2 no wake", wake_cnt - w0, 0);
    chk("R7 frame in SUSPEND2 no status", frame_stat_o, 1'b0);

    idle_inputs();
    wol_ev_en_i = 4'b0100;
    do_reset();
    enter(3'd4);
    w0 = wake_cnt;
    frame_pulse();
    chk("R7 frame blocked by event enable", wake_cnt - w0, 0);
    chk("R7 state kept SUSPEND3", state_o, 3'd4);
    @(negedge clk); wol_ev_en_i = 4'b0000;
    frame_pulse();
    chk("R7 frame wake SUSPEND3", wake_cnt - w0, 1);
    chk("R7 frame status", {frame_stat_o, pin_stat_o}, 12'h800);
    chk("R8 frame exit state", state_o, 3'd0);
    clear(12'h800);
    chk("R9 frame clear", frame_stat_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule